// File: doc/BRIEF.md
# Capture/Compare/PWM Channel Bank

A bank of identical capture/compare channels that all watch one shared 16-bit free-running count. Each channel owns a 16-bit value register (low and high byte), a 6-bit mode register and one pin. Depending on the mode bits, a channel does one of four things. It can latch the count when its input pin rises and/or falls. It can flag the moment the count equals its value register, which serves as a software timer. It can invert its output pin on that equality, which gives a high-speed output. It can also produce an 8-bit pulse-width-modulated output.

The count itself, the decoding of register addresses and the routing of interrupts live outside. The block receives the count value together with a one-cycle strobe that marks each new count. Register writes arrive as per-channel byte strobes with a shared data byte. A per-channel event flag is kept in one shared flag vector. Software clears it through a clear strobe.

In compare modes, loading the low value byte suspends comparison and loading the high byte resumes it, so a 16-bit target is never compared half-written. In PWM mode the high byte acts as a shadow of the duty value. It is copied into the low byte each time the count's low byte wraps to zero, so a new duty takes effect only at a period boundary.

Top module: `ccpBank`

## Requirements
- R1: After reset all value registers, mode registers, flags and output pins are zero.
- R2: Mode bit 5 (capture-on-rise) set: a rising edge on the channel pin, seen after a two-flop synchronizer and an edge stage, copies the count (high byte to the high register, low byte to the low register) and sets that channel's flag.
- R3: Mode bit 4 (capture-on-fall) set: a falling edge captures in the same way. An edge whose direction is not enabled leaves the registers and flag unchanged.
- R4: Mode bit 3 (compare enable) set: a count strobe whose count equals {high, low} sets the channel's flag. Unequal counts, cycles without a count strobe and a cleared bit 3 do not set it.
- R5: On such a match with mode bit 1 (toggle) set, the channel's output pin is inverted.
- R6: When mode bit 2 (match) or bit 1 (toggle) is set, a low-byte write clears bit 3 and a high-byte write sets it. When neither bit is set, value writes leave the mode register unchanged.
- R7: Mode bit 0 (PWM) set: on each count strobe the pin becomes 0 if the count low byte is below the low value byte, otherwise 1.
- R8: In PWM mode a count strobe whose low byte is zero copies the high value byte into the low value byte, and that copy governs the pin on that same count. A high-byte write alone does not change the low byte.
- R9: Writing a channel's mode register discards any pin edge already detected but not yet acted on, so it causes no capture.
- R10: When a capture and a toggle-enabled match fall in the same cycle, the capture loads the registers and sets the flag, and the pin is not toggled.
- R11: A flag stays set until its clear strobe. A flag set and a clear in the same cycle leave the flag set.
- R12: Channel n drives only flag bit n, pin n and its own register fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| timerVal | input | 16 | Shared count value |
| timerTick | input | 1 | High for one cycle when timerVal holds a new count |
| wrData | input | 8 | Write data byte for mode/value writes |
| wrMode | input | NUM_CH | Per-channel mode register write strobe (uses wrData[5:0]) |
| wrLow | input | NUM_CH | Per-channel low value byte write strobe |
| wrHigh | input | NUM_CH | Per-channel high value byte write strobe |
| flagClr | input | NUM_CH | Per-channel flag clear strobe |
| pinIn | input | NUM_CH | Channel pins as inputs (asynchronous) |
| pinOut | output | NUM_CH | Channel pins as outputs |
| flags | output | NUM_CH | Event flag vector, bit n for channel n |
| regLowOut | output | NUM_CH*8 | Low value bytes, channel n at [8n+7:8n] |
| regHighOut | output | NUM_CH*8 | High value bytes, channel n at [8n+7:8n] |
| modeOut | output | NUM_CH*6 | Mode registers, channel n at [6n+5:6n] |

## Verification
The hardest cases to reach are the races at a single cycle. One is the cycle in which a detected edge is pending while the mode register is rewritten. The other is the cycle in which a pending capture meets a count strobe that matches. The bench drives the pin on a falling clock edge and counts exactly three further edges, so that the edge stage holds the event. In that one cycle it then either writes the mode register or pulses the count strobe at a matching count. The PWM and compare behaviour is swept across all 256 low-byte counts for several duty values and targets, and every pin and flag value is predicted arithmetically.

// File: rtl/ccpPkg.sv
package ccpPkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = 2 * BYTE_W;
  localparam int MODE_W = 6;

  // Mode register layout, bit 5 down to bit 0
  typedef struct packed {
    logic capPos;   // 5: capture on rising pin edge
    logic capNeg;   // 4: capture on falling pin edge
    logic cmpEn;    // 3: comparator enable
    logic match;    // 2: match (software timer) mode
    logic toggle;   // 1: toggle pin on match
    logic pwm;      // 0: pulse-width modulation
  } modeT;

  // Strobes from control to datapath
  typedef struct packed {
    logic capture;  // latch count into value register
    logic wrLow;    // bus write of low byte
    logic wrHigh;   // bus write of high byte
    logic toggle;   // invert output pin
    logic pwmStep;  // refresh PWM pin level
    logic reload;   // copy high byte into low byte
  } strobeT;
endpackage

// File: rtl/ccpControl.sv
module ccpControl
  import ccpPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              pinIn,
  input  logic              wrMode,
  input  logic              wrLow,
  input  logic              wrHigh,
  input  logic [MODE_W-1:0] modeData,
  input  logic              timerTick,
  input  logic              timerLowZero,
  input  logic              hit,
  output strobeT            strobe,
  output modeT              mode,
  output logic              flagSet
);
  logic syncA, syncB, prevLvl;
  logic riseSeen, fallSeen;
  logic capNow, cmpHit;

  // pin synchronizer and previous-level stage
  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncA   <= 1'b0;
      syncB   <= 1'b0;
      prevLvl <= 1'b0;
    end else begin
      syncA   <= pinIn;
      syncB   <= syncA;
      prevLvl <= syncB;
    end
  end

  // pending edge events; a mode write discards them
  always_ff @(posedge clk) begin
    if (!rstN) begin
      riseSeen <= 1'b0;
      fallSeen <= 1'b0;
    end else if (wrMode) begin
      riseSeen <= 1'b0;
      fallSeen <= 1'b0;
    end else begin
      riseSeen <= syncB & ~prevLvl;
      fallSeen <= ~syncB & prevLvl;
    end
  end

  // mode register with compare-enable side effects of value writes
  always_ff @(posedge clk) begin
    if (!rstN) begin
      mode <= '0;
    end else if (wrMode) begin
      mode <= modeT'(modeData);
    end else if (mode.match || mode.toggle) begin
      if (wrHigh)
        mode.cmpEn <= 1'b1;
      else if (wrLow)
        mode.cmpEn <= 1'b0;
    end
  end

  always_comb begin
    capNow = ((mode.capPos & riseSeen) | (mode.capNeg & fallSeen)) & ~wrMode;
    cmpHit = mode.cmpEn & timerTick & hit;

    strobe.capture = capNow;
    strobe.wrLow   = wrLow;
    strobe.wrHigh  = wrHigh;
    strobe.toggle  = cmpHit & mode.toggle & ~mode.pwm & ~capNow;
    strobe.pwmStep = mode.pwm & timerTick;
    strobe.reload  = mode.pwm & timerTick & timerLowZero;

    flagSet = capNow | cmpHit;
  end

  // R9
  pend_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrMode |=> !strobe.capture);

  // R6
  ecom_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrLow && !wrHigh && !wrMode && (mode.match || mode.toggle)) |=> !mode.cmpEn);

  // R6
  ecom_on_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrHigh && !wrMode && (mode.match || mode.toggle)) |=> mode.cmpEn);

  // R6
  mode_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!wrMode && !mode.match && !mode.toggle) |=> $stable(mode));
endmodule

// File: rtl/ccpDatapath.sv
module ccpDatapath
  import ccpPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [CNT_W-1:0]  timerVal,
  input  logic [BYTE_W-1:0] wrData,
  input  strobeT            strobe,
  output logic              hit,
  output logic [BYTE_W-1:0] regLow,
  output logic [BYTE_W-1:0] regHigh,
  output logic              pinOut
);
  logic [BYTE_W-1:0] cntLow, cntHigh, effLow;
  logic              below;

  assign cntLow  = timerVal[BYTE_W-1:0];
  assign cntHigh = timerVal[CNT_W-1:BYTE_W];
  assign hit     = (cntLow == regLow) && (cntHigh == regHigh);

  // duty in effect for this count: reloaded value on the wrap count
  assign effLow = strobe.reload ? regHigh : regLow;
  assign below  = cntLow < effLow;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      regLow <= '0;
    end else if (strobe.wrLow) begin
      regLow <= wrData;
    end else if (strobe.capture) begin
      regLow <= cntLow;
    end else if (strobe.reload) begin
      regLow <= regHigh;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      regHigh <= '0;
    end else if (strobe.wrHigh) begin
      regHigh <= wrData;
    end else if (strobe.capture) begin
      regHigh <= cntHigh;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pinOut <= 1'b0;
    end else if (strobe.pwmStep) begin
      pinOut <= ~below;
    end else if (strobe.toggle) begin
      pinOut <= ~pinOut;
    end
  end

  // R2
  cap_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.capture && !strobe.wrLow && !strobe.wrHigh)
      |=> ({regHigh, regLow} == $past(timerVal)));

  // R5
  tog_flip_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.toggle && !strobe.pwmStep) |=> (pinOut != $past(pinOut)));

  // R8
  reload_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.reload && !strobe.capture && !strobe.wrLow) |=> (regLow == $past(regHigh)));

  // R7
  pwm_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.pwmStep && !strobe.toggle) |=> $stable(pinOut));
endmodule

// File: rtl/ccpBank.sv
module ccpBank
  import ccpPkg::*;
#(
  parameter int NUM_CH = 5
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [CNT_W-1:0]         timerVal,
  input  logic                     timerTick,
  input  logic [BYTE_W-1:0]        wrData,
  input  logic [NUM_CH-1:0]        wrMode,
  input  logic [NUM_CH-1:0]        wrLow,
  input  logic [NUM_CH-1:0]        wrHigh,
  input  logic [NUM_CH-1:0]        flagClr,
  input  logic [NUM_CH-1:0]        pinIn,
  output logic [NUM_CH-1:0]        pinOut,
  output logic [NUM_CH-1:0]        flags,
  output logic [NUM_CH*BYTE_W-1:0] regLowOut,
  output logic [NUM_CH*BYTE_W-1:0] regHighOut,
  output logic [NUM_CH*MODE_W-1:0] modeOut
);
  logic [NUM_CH-1:0] flagSet;
  logic              timerLowZero;

  assign timerLowZero = (timerVal[BYTE_W-1:0] == '0);

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : gChan
    strobeT strobe;
    modeT   mode;
    logic   hit;

    ccpControl uCtrl (
      .clk         (clk),
      .rstN        (rstN),
      .pinIn       (pinIn[ch]),
      .wrMode      (wrMode[ch]),
      .wrLow       (wrLow[ch]),
      .wrHigh      (wrHigh[ch]),
      .modeData    (wrData[MODE_W-1:0]),
      .timerTick   (timerTick),
      .timerLowZero(timerLowZero),
      .hit         (hit),
      .strobe      (strobe),
      .mode        (mode),
      .flagSet     (flagSet[ch])
    );

    ccpDatapath uData (
      .clk     (clk),
      .rstN    (rstN),
      .timerVal(timerVal),
      .wrData  (wrData),
      .strobe  (strobe),
      .hit     (hit),
      .regLow  (regLowOut[ch*BYTE_W +: BYTE_W]),
      .regHigh (regHighOut[ch*BYTE_W +: BYTE_W]),
      .pinOut  (pinOut[ch])
    );

    assign modeOut[ch*MODE_W +: MODE_W] = mode;

    // R11
    flag_set_chk: assert property (@(posedge clk) disable iff (!rstN)
      flagSet[ch] |=> flags[ch]);

    // R11
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
      (flags[ch] && !flagClr[ch]) |=> flags[ch]);
  end

  // shared flag vector: set wins over clear
  always_ff @(posedge clk) begin
    if (!rstN)
      flags <= '0;
    else
      flags <= (flags & ~flagClr) | flagSet;
  end
endmodule

// File: tb/sim_ccpBank.sv
module sim_ccpBank;
  localparam int N = 5;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [15:0]   timerVal = '0;
  logic          timerTick = 1'b0;
  logic [7:0]    wrData = '0;
  logic [N-1:0]  wrMode = '0, wrLow = '0, wrHigh = '0, flagClr = '0, pinIn = '0;
  logic [N-1:0]  pinOut, flags;
  logic [N*8-1:0] regLowOut, regHighOut;
  logic [N*6-1:0] modeOut;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  ccpBank #(.NUM_CH(N)) u0 (
    .clk(clk), .rstN(rstN), .timerVal(timerVal), .timerTick(timerTick),
    .wrData(wrData), .wrMode(wrMode), .wrLow(wrLow), .wrHigh(wrHigh),
    .flagClr(flagClr), .pinIn(pinIn), .pinOut(pinOut), .flags(flags),
    .regLowOut(regLowOut), .regHighOut(regHighOut), .modeOut(modeOut)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] valOf(input int ch);
    return {regHighOut[ch*8 +: 8], regLowOut[ch*8 +: 8]};
  endfunction

  function automatic logic [5:0] modeOf(input int ch);
    return modeOut[ch*6 +: 6];
  endfunction

  // kind 0 = mode, 1 = low byte, 2 = high byte
  task automatic writeReg(input int kind, input int ch, input logic [7:0] d);
    wrData = d;
    if (kind == 0) wrMode[ch] = 1'b1;
    else if (kind == 1) wrLow[ch] = 1'b1;
    else wrHigh[ch] = 1'b1;
    @(negedge clk);
    wrMode = '0; wrLow = '0; wrHigh = '0;
  endtask

  task automatic tickTo(input logic [15:0] v);
    timerVal = v;
    timerTick = 1'b1;
    @(negedge clk);
    timerTick = 1'b0;
  endtask

  task automatic clearFlags();
    flagClr = '1;
    @(negedge clk);
    flagClr = '0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 flags", flags, 0);
    chk("R1 pins", pinOut, 0);
    chk("R1 low", regLowOut, 0);
    chk("R1 high", regHighOut, 0);
    chk("R1 mode", modeOut, 0);
    rstN = 1'b1;
    @(negedge clk);

    // R2 rising capture on channel 0 (mode 0x20)
    writeReg(0, 0, 8'h20);
    timerVal = 16'hA5C3;
    pinIn[0] = 1'b1;
    repeat (6) @(negedge clk);
    chk("R2 capture value", valOf(0), 16'hA5C3);
    chk("R2 R12 flag", flags, 5'b00001);
    clearFlags();
    chk("R11 flag cleared", flags, 0);

    // R3 falling edge ignored when only rise enabled
    timerVal = 16'h0F0F;
    pinIn[0] = 1'b0;
    repeat (6) @(negedge clk);
    chk("R3 fall ignored value", valOf(0), 16'hA5C3);
    chk("R3 fall ignored flag", flags, 0);

    // R3 falling capture on channel 4 (mode 0x10), rise ignored
    writeReg(0, 4, 8'h10);
    pinIn[4] = 1'b1;
    repeat (6) @(negedge clk);
    chk("R3 rise ignored value", valOf(4), 0);
    chk("R3 rise ignored flag", flags, 0);
    timerVal = 16'h7E81;
    pinIn[4] = 1'b0;
    repeat (6) @(negedge clk);
    chk("R3 fall capture value", valOf(4), 16'h7E81);
    chk("R3 R12 fall flag", flags, 5'b10000);
    clearFlags();

    // R9 mode write while an edge is pending on channel 2
    writeReg(0, 2, 8'h20);
    timerVal = 16'h1111;
    pinIn[2] = 1'b1;
    repeat (3) @(negedge clk);
    writeReg(0, 2, 8'h20);
    repeat (4) @(negedge clk);
    chk("R9 no capture value", valOf(2), 0);
    chk("R9 no capture flag", flags, 0);

    // R6 compare enable side effects on channel 1
    writeReg(0, 1, 8'h0E);
    chk("R6 mode written", modeOf(1), 6'h0E);
    writeReg(1, 1, 8'h34);
    chk("R6 low write clears enable", modeOf(1), 6'h06);
    writeReg(2, 1, 8'h12);
    chk("R6 high write sets enable", modeOf(1), 6'h0E);
    writeReg(0, 2, 8'h08);
    writeReg(1, 2, 8'h77);
    chk("R6 low write no effect", modeOf(2), 6'h08);
    writeReg(0, 2, 8'h00);
    writeReg(2, 2, 8'h55);
    chk("R6 high write no effect", modeOf(2), 6'h00);

    // R4 R5 R11 compare sweep on channel 1, target 0x1234
    for (int v = 0; v < 256; v++) begin
      if (v == 8'h34) flagClr[1] = 1'b1;
      tickTo({8'h12, v[7:0]});
      flagClr = '0;
      chk("R4 R11 sweep flag", flags, (v >= 8'h34) ? 5'b00010 : 5'b00000);
      chk("R5 sweep pin", pinOut, (v >= 8'h34) ? 5'b00010 : 5'b00000);
    end
    clearFlags();
    timerVal = 16'h1234;
    repeat (3) @(negedge clk);
    chk("R4 no tick no flag", flags, 0);
    tickTo(16'h1334);
    chk("R4 high byte differs", flags, 0);
    writeReg(0, 1, 8'h06);
    tickTo(16'h1234);
    chk("R4 disabled no flag", flags, 0);
    chk("R5 disabled no toggle", pinOut, 5'b00010);

    // R10 capture meets a toggle match on channel 3
    writeReg(0, 3, 8'h2E);
    writeReg(1, 3, 8'h22);
    writeReg(2, 3, 8'h11);
    chk("R6 channel 3 enable", modeOf(3), 6'h2E);
    timerVal = 16'h1122;
    pinIn[3] = 1'b1;
    repeat (3) @(negedge clk);
    timerTick = 1'b1;
    @(negedge clk);
    timerTick = 1'b0;
    chk("R10 pin not toggled", pinOut, 5'b00010);
    chk("R10 capture value", valOf(3), 16'h1122);
    chk("R10 flag", flags, 5'b01000);
    tickTo(16'h1122);
    chk("R5 toggle after", pinOut, 5'b01010);
    clearFlags();

    // R7 PWM sweeps on channel 0
    writeReg(0, 0, 8'h01);
    foreach (pinIn[i]) pinIn[i] = 1'b0;
    for (int d = 0; d < 3; d++) begin
      logic [7:0] duty;
      duty = (d == 0) ? 8'd0 : (d == 1) ? 8'd64 : 8'd200;
      writeReg(2, 0, duty);
      writeReg(1, 0, duty);
      for (int v = 0; v < 256; v++) begin
        tickTo({8'h00, v[7:0]});
        chk("R7 pwm pin", pinOut[0], (v < duty) ? 1'b0 : 1'b1);
      end
    end

    // R8 shadow reload at low byte wrap
    writeReg(2, 0, 8'h30);
    chk("R8 low held after high write", regLowOut[7:0], 8'd200);
    tickTo(16'h0100);
    chk("R8 reloaded at wrap", regLowOut[7:0], 8'h30);
    chk("R8 new duty at wrap", pinOut[0], 1'b0);
    tickTo(16'h0130);
    chk("R8 new duty edge", pinOut[0], 1'b1);
    chk("R12 other pins", pinOut[4:1], 4'b0101);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule